// File: doc/BRIEF.md
# Shared-Multiplier 9/7 Lifting Wavelet Engine

This block computes the one-dimensional (9,7) biorthogonal wavelet transform by lifting, using a single multiply-add element that is reused for all four lifting steps. A free-running four-state phase counter selects, in turn, the predict-one, update-one, predict-two and update-two steps. Each step has the form `centre + coef * (left + right)`. The operands come from the step just finished and from history registers that advance once per four-cycle frame.

A pair of samples (one even, one odd) may enter once per frame, on the phase-0 cycle. After the fourth step of that frame, a separate registered scaling stage multiplies the detail by the inverse scale constant and the approximation by the scale constant. It then presents both with a one-cycle valid pulse. Arithmetic is two's-complement fixed point. The constants are held with two integer bits and `FRAC` fractional bits, and every product is rounded to nearest before it is added. History before the first accepted pair after reset is zero.

Top module: `dwt97_lift_core`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `out_valid` is 0 and `lo_out` and `hi_out` are 0. Reset also clears all lifting history to zero.
- R2: The phase counts 0,1,2,3 repeatedly, with phase 0 on the first rising edge after reset is released. A pair is accepted only when `in_valid` is 1 on a phase-0 edge. The values of `in_valid`, `in_even` and `in_odd` on phases 1 to 3 have no effect.
- R3: `out_valid` is high for exactly one cycle, starting right after the phase-3 edge of a frame whose pair was accepted. It is 0 at all other times, so two pulses are at least four cycles apart.
- R4: With `FRAC`=14 the lifting constants are -25987, -868, 14466 and 7266. Each step adds `round(coef*(left+right))` to its centre, where `round(p) = floor((p + 8192) / 16384)`.
- R5: Number the accepted pairs k = 0,1,... with even samples x[2k] and odd samples x[2k+1], and take samples before k=0 as zero. Then d1[n] = x[2n+1] + round(A*(x[2n]+x[2n+2])), s1[n] = x[2n] + round(B*(d1[n-1]+d1[n])), d2[n] = d1[n] + round(C*(s1[n]+s1[n+1])) and s2[n] = s1[n] + round(D*(d2[n-1]+d2[n])). The pulse following pair k carries d2[k-2] and s2[k-2].
- R6: With the default `SWAP_SCALE`=0, `hi_out` = round(14252*d2) and `lo_out` = round(18835*s2). With `SWAP_SCALE`=1 the two scale constants trade places.
- R7: A frame whose phase-0 edge has `in_valid` 0 changes no history. The next accepted pair continues the sequence as if the idle frame were absent.
- R8: `lo_out` and `hi_out` hold their values on every cycle where `out_valid` is 0.
- R9: For a constant input held long enough to fill the history, `hi_out` stays within 4 of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Pair present; sampled on phase 0 only |
| in_even | input | DW | Even sample, signed |
| in_odd | input | DW | Odd sample, signed |
| out_valid | output | 1 | One-cycle pulse for a new coefficient pair |
| lo_out | output | DW+GUARD | Scaled approximation coefficient, signed |
| hi_out | output | DW+GUARD | Scaled detail coefficient, signed |

## Verification
The bound checker watches, on every cycle, the following properties. The valid pulse lasts one cycle and has at least three quiet cycles after it. It follows only a phase-3 edge of a running frame. The captured even sample never changes away from phase 0. The outputs hold between pulses, and the reset values appear as stated. Only the bench scenarios can show that the coefficient values are right, because that needs the lifting recurrence over many pairs. The same holds for idle frames leaving the sequence unbroken, for off-phase inputs leaving the numbers untouched, and for a constant input driving the detail output to zero.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;

   localparam int  LIFT_STEPS = 4;
   localparam real LIFT_A     = -1.586134342;
   localparam real LIFT_B     = -0.05298011854;
   localparam real LIFT_C     = 0.8829110762;
   localparam real LIFT_D     = 0.4435068522;
   localparam real LIFT_K     = 1.149604398;

   typedef enum logic [1:0] {
      PH_PRED1 = 2'd0,
      PH_UPD1  = 2'd1,
      PH_PRED2 = 2'd2,
      PH_UPD2  = 2'd3
   } phase_t;

   // Real constant to signed fixed point with 'frac' fractional bits, round to nearest.
   function automatic int q_coef(real v, int frac);
      return $rtoi($floor(v * (2.0 ** frac) + 0.5));
   endfunction

endpackage

// File: rtl/dwt97_phase.sv
module dwt97_phase #(
   parameter int STEPS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic [$clog2(STEPS)-1:0] phase
);
   localparam int SW = $clog2(STEPS);
   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              phase <= '0;
      else if (phase == LAST)  phase <= '0;
      else                     phase <= phase + SW'(1);
   end
endmodule

// File: rtl/dwt97_mac.sv
module dwt97_mac #(
   parameter int IW   = 20,
   parameter int CW   = 16,
   parameter int FRAC = 14
) (
   input  logic signed [IW-1:0] centre,
   input  logic signed [IW-1:0] left,
   input  logic signed [IW-1:0] right,
   input  logic signed [CW-1:0] coef,
   output logic signed [IW-1:0] result
);
   localparam int PW = IW + 1 + CW;

   logic signed [IW:0]   pair_sum;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] prod_rnd;

   always_comb begin
      pair_sum = (IW+1)'(left) + (IW+1)'(right);
      prod     = PW'(pair_sum) * PW'(coef);
      prod_rnd = prod + (PW'(1) <<< (FRAC - 1));
      result   = IW'(PW'(centre) + (prod_rnd >>> FRAC));
   end
endmodule

// File: rtl/dwt97_scale.sv
module dwt97_scale
   import dwt97_pkg::*;
#(
   parameter int IW         = 20,
   parameter int OW         = 20,
   parameter int CW         = 16,
   parameter int FRAC       = 14,
   parameter bit SWAP_SCALE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic signed [IW-1:0] lo_in,
   input  logic signed [IW-1:0] hi_in,
   output logic                 out_valid,
   output logic signed [OW-1:0] lo_out,
   output logic signed [OW-1:0] hi_out
);
   localparam int PW   = IW + CW;
   localparam int KUP  = q_coef(LIFT_K, FRAC);
   localparam int KDN  = q_coef(1.0 / LIFT_K, FRAC);

   logic signed [CW-1:0] k_lo, k_hi;
   logic signed [PW-1:0] lo_p, hi_p;
   logic signed [OW-1:0] lo_n, hi_n;

   generate
      if (SWAP_SCALE) begin : g_swapped
         assign k_lo = CW'(KDN);
         assign k_hi = CW'(KUP);
      end else begin : g_normal
         assign k_lo = CW'(KUP);
         assign k_hi = CW'(KDN);
      end
   endgenerate

   always_comb begin
      lo_p = PW'(lo_in) * PW'(k_lo) + (PW'(1) <<< (FRAC - 1));
      hi_p = PW'(hi_in) * PW'(k_hi) + (PW'(1) <<< (FRAC - 1));
      lo_n = OW'(lo_p >>> FRAC);
      hi_n = OW'(hi_p >>> FRAC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         lo_out    <= '0;
         hi_out    <= '0;
      end else begin
         out_valid <= load;
         if (load) begin
            lo_out <= lo_n;
            hi_out <= hi_n;
         end
      end
   end
endmodule

// File: rtl/dwt97_lift_core.sv
module dwt97_lift_core
   import dwt97_pkg::*;
#(
   parameter int DW         = 16,
   parameter int GUARD      = 4,
   parameter int FRAC       = 14,
   parameter bit SWAP_SCALE = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic signed [DW-1:0]      in_even,
   input  logic signed [DW-1:0]      in_odd,
   output logic                      out_valid,
   output logic signed [DW+GUARD-1:0] lo_out,
   output logic signed [DW+GUARD-1:0] hi_out
);
   localparam int IW = DW + GUARD;
   localparam int CW = FRAC + 2;
   localparam logic signed [CW-1:0] CA = CW'(q_coef(LIFT_A, FRAC));
   localparam logic signed [CW-1:0] CB = CW'(q_coef(LIFT_B, FRAC));
   localparam logic signed [CW-1:0] CC = CW'(q_coef(LIFT_C, FRAC));
   localparam logic signed [CW-1:0] CD = CW'(q_coef(LIFT_D, FRAC));

   generate
      if (DW < 4)                  begin : g_bad_dw    $error("DW must be at least 4");          end
      if (GUARD < 4)               begin : g_bad_guard $error("GUARD must be at least 4");       end
      if (FRAC < 8 || FRAC > 24)   begin : g_bad_frac  $error("FRAC must lie in 8..24");         end
      if (LIFT_STEPS != 4)         begin : g_bad_steps $error("schedule assumes four steps");    end
   endgenerate

   logic [1:0] ph_cnt;
   phase_t     ph;

   dwt97_phase #(.STEPS(LIFT_STEPS)) i_phase (
      .clk(clk), .rst_n(rst_n), .phase(ph_cnt)
   );
   assign ph = phase_t'(ph_cnt);

   logic signed [IW-1:0] ext_even, ext_odd;
   logic signed [IW-1:0] e_cur, o_cur, e_prev, o_prev;
   logic signed [IW-1:0] p1_r, u1_r, p2_r, p1_old, u1_old, p2_old;
   logic signed [IW-1:0] op_c, op_l, op_r, mac_res;
   logic signed [CW-1:0] op_k;
   logic                 run;

   assign ext_even = IW'(in_even);
   assign ext_odd  = IW'(in_odd);

   // Operand routing for the shared element, one lifting step per phase.
   always_comb begin
      case (ph)
         PH_PRED1: begin op_c = o_prev; op_l = e_prev; op_r = ext_even; op_k = CA; end
         PH_UPD1:  begin op_c = e_prev; op_l = p1_old; op_r = p1_r;     op_k = CB; end
         PH_PRED2: begin op_c = p1_old; op_l = u1_old; op_r = u1_r;     op_k = CC; end
         PH_UPD2:  begin op_c = u1_old; op_l = p2_old; op_r = p2_r;     op_k = CD; end
         default:  begin op_c = '0;     op_l = '0;     op_r = '0;       op_k = '0; end
      endcase
   end

   dwt97_mac #(.IW(IW), .CW(CW), .FRAC(FRAC)) i_mac (
      .centre(op_c), .left(op_l), .right(op_r), .coef(op_k), .result(mac_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         e_cur  <= '0;  o_cur  <= '0;
         e_prev <= '0;  o_prev <= '0;
         p1_r   <= '0;  u1_r   <= '0;  p2_r   <= '0;
         p1_old <= '0;  u1_old <= '0;  p2_old <= '0;
      end else begin
         case (ph)
            PH_PRED1: begin
               run <= in_valid;
               if (in_valid) begin
                  p1_r  <= mac_res;
                  e_cur <= ext_even;
                  o_cur <= ext_odd;
               end
            end
            PH_UPD1:  if (run) u1_r <= mac_res;
            PH_PRED2: if (run) p2_r <= mac_res;
            PH_UPD2:  if (run) begin
               e_prev <= e_cur;
               o_prev <= o_cur;
               p1_old <= p1_r;
               u1_old <= u1_r;
               p2_old <= p2_r;
            end
            default: ;
         endcase
      end
   end

   dwt97_scale #(
      .IW(IW), .OW(IW), .CW(CW), .FRAC(FRAC), .SWAP_SCALE(SWAP_SCALE)
   ) i_scale (
      .clk(clk), .rst_n(rst_n),
      .load((ph == PH_UPD2) && run),
      .lo_in(mac_res), .hi_in(p2_r),
      .out_valid(out_valid), .lo_out(lo_out), .hi_out(hi_out)
   );
endmodule

// File: rtl/dwt97_lift_chk.sv
module dwt97_lift_chk #(
   parameter int IW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    ph,
   input logic          run,
   input logic [IW-1:0] e_cur,
   input logic          out_valid,
   input logic [IW-1:0] lo_out,
   input logic [IW-1:0] hi_out
);
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && lo_out == '0 && hi_out == '0));

   p_off_phase_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != 2'd0) |=> $stable(e_cur));

   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid ##1 !out_valid ##1 !out_valid);

   p_pulse_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(ph) == 2'd3 && $past(run)));

   p_output_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(lo_out) && $stable(hi_out)));
endmodule

bind dwt97_lift_core dwt97_lift_chk #(.IW(DW + GUARD)) i_lift_chk (
   .clk(clk), .rst_n(rst_n), .ph(ph_cnt), .run(run), .e_cur(e_cur),
   .out_valid(out_valid), .lo_out(lo_out), .hi_out(hi_out)
);

// File: tb/test_dwt97_lift_core.sv
`timescale 1ns/1ps
module test_dwt97_lift_core;
   localparam int DW   = 16;
   localparam int OW   = 20;
   localparam int MAXF = 256;
   localparam int OFF  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] in_even = '0, in_odd = '0;
   logic out_valid;
   logic signed [OW-1:0] lo_out, hi_out;

   always #2.5 clk = ~clk;

   dwt97_lift_core i_dwt97_lift_core (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_even(in_even), .in_odd(in_odd),
      .out_valid(out_valid), .lo_out(lo_out), .hi_out(hi_out)
   );

   int n_chk = 0, n_fail = 0;
   int k_idx = 0;
   longint ex[0:MAXF+OFF], ox[0:MAXF+OFF];
   longint d1[0:MAXF+OFF], s1[0:MAXF+OFF], d2[0:MAXF+OFF], s2[0:MAXF+OFF];
   longint exp_lo = 0, exp_hi = 0;

   function automatic longint rq(longint c, longint v);
      return (c * v + 64'sd8192) >>> 14;
   endfunction

   task automatic chk(input string req, input longint act, input longint expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i <= MAXF + OFF; i++) begin
         ex[i] = 0; ox[i] = 0; d1[i] = 0; s1[i] = 0; d2[i] = 0; s2[i] = 0;
      end
      k_idx = 0; exp_lo = 0; exp_hi = 0;
   endtask

   // Lifting recurrence on the pair index, as written in R4/R5/R6.
   task automatic model_pair(input longint ev, input longint od);
      int n;
      n = k_idx + OFF;
      ex[n] = ev; ox[n] = od;
      d1[n-1] = ox[n-1] + rq(-25987, ex[n-1] + ex[n]);
      s1[n-1] = ex[n-1] + rq(-868,   d1[n-2] + d1[n-1]);
      d2[n-2] = d1[n-2] + rq(14466,  s1[n-2] + s1[n-1]);
      s2[n-2] = s1[n-2] + rq(7266,   d2[n-3] + d2[n-2]);
      exp_hi  = rq(14252, d2[n-2]);
      exp_lo  = rq(18835, s2[n-2]);
      k_idx++;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 out_valid in reset", longint'(out_valid), 0);
      chk("R1 lo_out in reset", longint'(lo_out), 0);
      chk("R1 hi_out in reset", longint'(hi_out), 0);
      model_clear();
      rst_n = 1'b1;
   endtask

   // One four-cycle frame, entered and left on a falling edge; the next rising edge is phase 0.
   task automatic frame(input bit v, input int ev, input int od, input string tag);
      in_valid = v; in_even = DW'(ev); in_odd = DW'(od);
      if (v) model_pair(longint'($signed(DW'(ev))), longint'($signed(DW'(od))));
      for (int p = 0; p < 3; p++) begin
         @(negedge clk);
         chk("R3 no pulse mid-frame", longint'(out_valid), 0);
         chk("R8 lo_out holds", longint'(lo_out), exp_lo - (v ? exp_lo : 0) + (v ? prev_lo : 0));
         chk("R8 hi_out holds", longint'(hi_out), exp_hi - (v ? exp_hi : 0) + (v ? prev_hi : 0));
         // Off-phase stimulus that must have no effect (R2).
         in_valid = 1'b1;
         in_even = DW'($urandom);
         in_odd  = DW'($urandom);
      end
      @(negedge clk);
      chk({"R3 pulse after frame ", tag}, longint'(out_valid), longint'(v));
      chk({"R5 R6 lo_out ", tag}, longint'(lo_out), exp_lo);
      chk({"R5 R6 hi_out ", tag}, longint'(hi_out), exp_hi);
      prev_lo = exp_lo; prev_hi = exp_hi;
   endtask

   longint prev_lo = 0, prev_hi = 0;
   bit done = 1'b0;

   initial begin
      model_clear();
      do_reset();
      prev_lo = 0; prev_hi = 0;
      // R1: first cycle after release
      @(posedge clk); #1;
      chk("R1 out_valid after release", longint'(out_valid), 0);
      do_reset();
      prev_lo = 0; prev_hi = 0;

      // R5: all-zero pairs
      for (int i = 0; i < 3; i++) frame(1'b1, 0, 0, "R5 zeros");
      // R4 R5: impulse on an even sample then an odd sample
      frame(1'b1, 1000, 0, "R4 impulse even");
      for (int i = 0; i < 4; i++) frame(1'b1, 0, 0, "R4 impulse tail");
      frame(1'b1, 0, -777, "R4 impulse odd");
      for (int i = 0; i < 4; i++) frame(1'b1, 0, 0, "R4 odd tail");
      // R7: idle frames interleaved with data
      for (int i = 0; i < 12; i++) begin
         frame(1'b1, 300 * i - 1700, 5000 - 450 * i, "R7 data");
         if (i % 3 == 1) frame(1'b0, 9999, -9999, "R7 idle");
         if (i % 4 == 2) frame(1'b0, -123, 456, "R7 idle");
      end
      // R4: random pairs
      for (int i = 0; i < 40; i++)
         frame(1'b1, int'($signed(DW'($urandom))), int'($signed(DW'($urandom))), "R4 random");
      // R4: extremes, alternating sign
      for (int i = 0; i < 8; i++)
         frame(1'b1, (i % 2) ? -32768 : 32767, (i % 2) ? 32767 : -32768, "R4 extremes");

      // R9: constant input after a fresh reset
      do_reset();
      prev_lo = 0; prev_hi = 0;
      for (int i = 0; i < 12; i++) begin
         frame(1'b1, 1000, 1000, "R9 constant");
         if (i >= 5) begin
            n_chk++;
            if (hi_out > 4 || hi_out < -4) begin
               n_fail++;
               $display("FAIL R9 detail not near zero actual=%0d expected=0", hi_out);
            end
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule